// File: doc/BRIEF.md
# Peripheral Response Timeout Controller

This block sits in the command path of a display serial link host. After the host finishes a link transaction, the peripheral may need time to respond. During that time the block keeps the link parked in the LP-11 stop state. The hold lasts a programmable number of lane byte clock periods. While `hold_idle` is high, the surrounding transmit logic must not launch a new transaction.

Five kinds of transaction end can start the hold:

- a read sent in high-speed mode;
- a read sent in low-power mode;
- a write sent in high-speed mode;
- a write sent in low-power mode;
- a bus turnaround that has completed.

Each kind has its own 16-bit count. A count of zero switches that kind off.

The whole mechanism applies only in command mode. In video mode the refresh schedule must never be stretched, so the block does nothing there. A separate mode input restricts the trigger to bus turnaround completions only, for use with adaptive command operation. When the count runs out, the block gives a one-cycle `expired` pulse and lowers `hold_idle` in that same cycle.

Top module: `resp_timeout_ctrl`

## Requirements
- R1: After reset, `hold_idle` and `expired` are both low.
- R2: An accepted event strobe loads the count of its category. From the next cycle, `hold_idle` is high. The count then drops by one on each clock in which `byte_tick` is high.
- R3: The event is followed by N ticks, where N is the loaded count. On the Nth tick, `expired` goes high for exactly one cycle and `hold_idle` goes low in that same cycle.
- R4: In cycles where `byte_tick` is low and no event is accepted, the count holds its value, and so does `hold_idle`.
- R5: A category whose count is zero ignores its strobe. An idle controller stays idle, and a running count is not disturbed.
- R6: High-speed and low-power requests of the same direction are separate categories. Each uses its own count.
- R7: While `cmd_mode` is low (video mode), all strobes are ignored. Dropping `cmd_mode` abandons a running count with no `expired` pulse.
- R8: While `bta_only` is high, only the bus turnaround strobe (bit 2) is accepted. Read and write strobes are ignored.
- R9: An event accepted while a count is running reloads the counter with the count of the new event's category.
- R10: The strobe vector `ev_stb` uses these bit positions: bit 0 high-speed read, bit 1 low-power read, bit 2 bus turnaround done, bit 3 high-speed write, bit 4 low-power write. When several accepted strobes arrive together, the lowest bit wins.
- R11: An event accepted in a cycle that also carries `byte_tick` loads its full count. The tick in that cycle is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_tick | input | 1 | Count-down enable, one per byte clock period |
| cmd_mode | input | 1 | 1 = command mode, 0 = video mode |
| bta_only | input | 1 | 1 = only bus turnaround completions start the hold |
| ev_stb | input | 5 | Transaction-end strobes (bit order as in R10) |
| tmo_hs_rd | input | 16 | Count after a high-speed read |
| tmo_lp_rd | input | 16 | Count after a low-power read |
| tmo_bta | input | 16 | Count after a completed bus turnaround |
| tmo_hs_wr | input | 16 | Count after a high-speed write |
| tmo_lp_wr | input | 16 | Count after a low-power write |
| hold_idle | output | 1 | Keep the link in LP-11, issue no transaction |
| expired | output | 1 | One-cycle pulse when the count runs out |

## Verification
The assertions assume that the count inputs stay stable while a strobe is presented, and that the strobes and `cmd_mode` are synchronous to `clk`. The stimulus follows both assumptions:

- It changes the count inputs only while the controller is idle.
- It drives every input on the falling clock edge and samples on the falling edge.

Strobes last exactly one cycle, except in the cases that deliberately overlap a strobe with a tick or with a running count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned NUM_CAT = 5;
  localparam int unsigned CNT_W   = 16;

  // Category index equals the strobe bit position; lower index has priority.
  typedef enum logic [2:0] {
    CAT_HS_RD = 3'd0,
    CAT_LP_RD = 3'd1,
    CAT_BTA   = 3'd2,
    CAT_HS_WR = 3'd3,
    CAT_LP_WR = 3'd4
  } cat_e;

  function automatic logic cat_is_bta(int unsigned idx);
    return idx == int'(CAT_BTA);
  endfunction
endpackage

// File: rtl/rtc_event_sel.sv
module rtc_event_sel #(
  parameter int unsigned NUM_CAT = rtc_pkg::NUM_CAT,
  parameter int unsigned CNT_W   = rtc_pkg::CNT_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CAT-1:0]            ev_stb,
  input  logic                          cmd_mode,
  input  logic                          bta_only,
  input  logic [NUM_CAT-1:0][CNT_W-1:0] tmo_vals,
  output logic                          load_o,
  output logic [CNT_W-1:0]              load_val_o
);
  logic [NUM_CAT-1:0] qual;
  logic [NUM_CAT-1:0] grant;

  // Per-category qualification: command mode, nonzero count, mode filter.
  for (genvar g = 0; g < NUM_CAT; g++) begin : g_qual
    localparam bit IS_BTA = rtc_pkg::cat_is_bta(g);
    assign qual[g] = ev_stb[g] && cmd_mode && (tmo_vals[g] != '0)
                     && (IS_BTA || !bta_only);
  end

  // Fixed priority: lowest qualified index wins.
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NUM_CAT; i++) begin
      if (qual[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    load_val_o = '0;
    for (int i = 0; i < NUM_CAT; i++) begin
      if (grant[i]) load_val_o = load_val_o | tmo_vals[i];
    end
  end

  assign load_o = |grant;

  // R10: never more than one category granted at once
  a_r10_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R5: a load never carries a zero count
  a_r5_no_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> (load_val_o != '0));

  // R8: in turnaround-only mode, only the turnaround strobe may win
  a_r8_bta_filter: assert property (@(posedge clk) disable iff (!rst_n)
    (bta_only && load_o) |-> ev_stb[int'(rtc_pkg::CAT_BTA)]);
endmodule

// File: rtl/rtc_down_counter.sv
module rtc_down_counter #(
  parameter int unsigned CNT_W = rtc_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_mode,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             hold_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             exp_q, exp_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    exp_d  = 1'b0;
    cnt_en = 1'b0;
    if (!cmd_mode) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d  = cnt_q - ONE;
      cnt_en = 1'b1;
      exp_d  = (cnt_q == ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign hold_o    = (cnt_q != '0);
  assign expired_o = exp_q;

  // R9: an accepted load sets the count to the selected value
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode && load) |=> (cnt_q == $past(load_val)));

  // R4: without tick or load the count stays put
  a_r4_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode && !load && !tick) |=> $stable(cnt_q));

  // R3: expired lasts one cycle and coincides with release
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |=> !expired_o);
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |-> !hold_o);
endmodule

// File: rtl/resp_timeout_ctrl.sv
module resp_timeout_ctrl #(
  parameter int unsigned NUM_CAT = rtc_pkg::NUM_CAT,
  parameter int unsigned CNT_W   = rtc_pkg::CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_tick,
  input  logic               cmd_mode,
  input  logic               bta_only,
  input  logic [NUM_CAT-1:0] ev_stb,
  input  logic [CNT_W-1:0]   tmo_hs_rd,
  input  logic [CNT_W-1:0]   tmo_lp_rd,
  input  logic [CNT_W-1:0]   tmo_bta,
  input  logic [CNT_W-1:0]   tmo_hs_wr,
  input  logic [CNT_W-1:0]   tmo_lp_wr,
  output logic               hold_idle,
  output logic               expired
);
  logic [NUM_CAT-1:0][CNT_W-1:0] tmo_vals;
  logic                          load;
  logic [CNT_W-1:0]              load_val;

  always_comb begin
    tmo_vals = '0;
    tmo_vals[int'(rtc_pkg::CAT_HS_RD)] = tmo_hs_rd;
    tmo_vals[int'(rtc_pkg::CAT_LP_RD)] = tmo_lp_rd;
    tmo_vals[int'(rtc_pkg::CAT_BTA)]   = tmo_bta;
    tmo_vals[int'(rtc_pkg::CAT_HS_WR)] = tmo_hs_wr;
    tmo_vals[int'(rtc_pkg::CAT_LP_WR)] = tmo_lp_wr;
  end

  rtc_event_sel #(.NUM_CAT(NUM_CAT), .CNT_W(CNT_W)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_stb     (ev_stb),
    .cmd_mode   (cmd_mode),
    .bta_only   (bta_only),
    .tmo_vals   (tmo_vals),
    .load_o     (load),
    .load_val_o (load_val)
  );

  rtc_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_mode  (cmd_mode),
    .tick      (byte_tick),
    .load      (load),
    .load_val  (load_val),
    .hold_o    (hold_idle),
    .expired_o (expired)
  );

  // R7: video mode leaves the link free and never signals expiry
  a_r7_video_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_mode |=> (!hold_idle && !expired));

  // R2: an accepted event raises the hold on the next cycle
  a_r2_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> hold_idle);
endmodule

// File: tb/test_resp_timeout_ctrl.sv
module test_resp_timeout_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_tick, cmd_mode, bta_only;
  logic [4:0]  ev_stb;
  logic [15:0] tmo_hs_rd, tmo_lp_rd, tmo_bta, tmo_hs_wr, tmo_lp_wr;
  logic        hold_idle, expired;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  resp_timeout_ctrl i_resp_timeout_ctrl (
    .clk(clk), .rst_n(rst_n), .byte_tick(byte_tick), .cmd_mode(cmd_mode),
    .bta_only(bta_only), .ev_stb(ev_stb),
    .tmo_hs_rd(tmo_hs_rd), .tmo_lp_rd(tmo_lp_rd), .tmo_bta(tmo_bta),
    .tmo_hs_wr(tmo_hs_wr), .tmo_lp_wr(tmo_lp_wr),
    .hold_idle(hold_idle), .expired(expired)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(int a, int b, int c, int d, int e);
    tmo_hs_rd = 16'(a); tmo_lp_rd = 16'(b); tmo_bta = 16'(c);
    tmo_hs_wr = 16'(d); tmo_lp_wr = 16'(e);
  endtask

  // Present strobes for one cycle (optionally with a tick in the same cycle).
  task automatic fire(logic [4:0] mask, logic with_tick = 1'b0);
    @(negedge clk);
    ev_stb = mask; byte_tick = with_tick;
    @(negedge clk);
    ev_stb = '0; byte_tick = 1'b0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      byte_tick = 1'b1;
      repeat (n) @(negedge clk);
      byte_tick = 1'b0;
    end
  endtask

  // Counter already loaded with val: check full countdown and pulse.
  task automatic expect_expire(int val, string tag);
    check({tag, " hold at start"}, hold_idle, 1);
    ticks(val - 1);
    check({tag, " hold before end"}, hold_idle, 1);
    check({tag, " no early expiry"}, expired, 0);
    ticks(1);
    check({tag, " expired pulse"}, expired, 1);
    check({tag, " released"}, hold_idle, 0);
    @(negedge clk);
    check({tag, " pulse one cycle"}, expired, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; byte_tick = 0; cmd_mode = 1; bta_only = 0; ev_stb = '0;
    set_cfg(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 hold after reset", hold_idle, 0);
    check("R1 expired after reset", expired, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_each_category;   // R2 R3 R6
    set_cfg(3, 5, 4, 6, 7);
    fire(5'b00001); expect_expire(3, "R2 R3 hs read");
    fire(5'b00010); expect_expire(5, "R6 lp read");
    fire(5'b00100); expect_expire(4, "R2 bta");
    fire(5'b01000); expect_expire(6, "R6 hs write");
    fire(5'b10000); expect_expire(7, "R6 lp write");
  endtask

  task automatic t_stall;           // R4
    set_cfg(4, 0, 0, 0, 0);
    fire(5'b00001);
    ticks(2);
    repeat (10) @(negedge clk);
    check("R4 held without tick", hold_idle, 1);
    check("R4 no expiry without tick", expired, 0);
    ticks(1);
    check("R4 still holding", hold_idle, 1);
    ticks(1);
    check("R4 expires on 4th tick", expired, 1);
    @(negedge clk);
  endtask

  task automatic t_zero_disable;    // R5 R6
    set_cfg(0, 6, 0, 0, 0);
    fire(5'b00001);
    check("R5 R6 zero hs read ignored", hold_idle, 0);
    fire(5'b00010);
    ticks(2);
    fire(5'b00001);
    ticks(3);
    check("R5 running count undisturbed", hold_idle, 1);
    ticks(1);
    check("R5 original schedule kept", expired, 1);
    @(negedge clk);
  endtask

  task automatic t_video;           // R7
    set_cfg(5, 5, 5, 5, 5);
    cmd_mode = 0;
    fire(5'b11111);
    check("R7 video strobes ignored", hold_idle, 0);
    cmd_mode = 1;
    fire(5'b00001);
    ticks(2);
    @(negedge clk); cmd_mode = 0;
    @(negedge clk); cmd_mode = 1;
    check("R7 count abandoned", hold_idle, 0);
    begin
      int seen = 0;
      byte_tick = 1'b1;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (expired) seen++;
      end
      byte_tick = 1'b0;
      check("R7 no expiry after abandon", seen, 0);
    end
  endtask

  task automatic t_bta_only;        // R8
    set_cfg(3, 3, 4, 3, 3);
    bta_only = 1;
    fire(5'b11000);
    check("R8 writes ignored", hold_idle, 0);
    fire(5'b00011);
    check("R8 reads ignored", hold_idle, 0);
    fire(5'b00100); expect_expire(4, "R8 bta accepted");
    bta_only = 0;
  endtask

  task automatic t_reload;          // R9
    set_cfg(8, 0, 0, 2, 0);
    fire(5'b00001);
    ticks(3);
    fire(5'b01000);
    expect_expire(2, "R9 reload with hs write");
  endtask

  task automatic t_priority;        // R10
    set_cfg(0, 5, 3, 6, 7);
    fire(5'b11100); expect_expire(3, "R10 bta beats writes");
    fire(5'b00011); expect_expire(5, "R10 lp read wins over zero hs read");
    fire(5'b11000); expect_expire(6, "R10 hs write beats lp write");
  endtask

  task automatic t_tick_collide;    // R11
    set_cfg(4, 0, 0, 0, 0);
    fire(5'b00001, 1'b1);
    expect_expire(4, "R11 load beats tick");
  endtask

  task automatic t_long;            // R2 R3 wide count
    set_cfg(0, 0, 300, 0, 0);
    fire(5'b00100);
    expect_expire(300, "R3 long count");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_each_category();
    t_stall();
    t_zero_disable();
    t_video();
    t_bta_only();
    t_reload();
    t_priority();
    t_tick_collide();
    t_long();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule